// File: doc/BRIEF.md
# Low-speed USB single-line bit transceiver

This block times the bits on one data line of a low-speed USB link. It runs from a clock-enable tick of about 24 MHz, and one bit lasts 16 ticks. In transmit mode a producer hands it J or K symbols over a valid/ready pair. Each accepted symbol drives the line for exactly one bit period, and a symbol queued in time follows the previous one with no gap. When no symbol is pending, the block releases the line so that the external weak pull-down holds it low.

In receive mode, raising the receive enable starts a search for the first rising edge. If that edge does not show up within 17 bit periods, the block reports a sync timeout. Otherwise it samples the line half a bit after the edge. From then on it looks for the opposite edge after every sample. When that edge arrives, the next sample is re-centred half a bit after it. If a whole bit period passes with no edge, the previous value is emitted again. Each bit leaves on a one-cycle valid strobe. The line input passes through a two-flop synchroniser first. Line coding, stuffing, framing and the second data line are handled elsewhere.

Top module: `lsusb_bit_xcvr`

## Requirements
- R1: After reset, line_oe, line_out, rx_valid and sync_fail are 0, and tx_ready is 1 while mode_rx is 0.
- R2: An accepted symbol with tx_sym=0 (J) drives line_out low, and one with tx_sym=1 (K) drives it high. line_oe is 1 from the clock after acceptance.
- R3: An accepted symbol holds the line for exactly 16 ticks. tx_ready stays 0 until the clock that carries the 16th tick.
- R4: A symbol that is pending on the 16th tick is taken on that same edge, so the next symbol starts exactly 16 ticks after the previous one with no release in between. With nothing pending, the line is released after 16 ticks (line_oe=0, line_out=0).
- R5: While receiving, with the line low, sync_fail pulses 272 ticks after rx_en rises if no rising edge was detected. A rising edge detected on the 272nd tick is still accepted.
- R6: A change of line_in applied just after a tick is detected on the second following tick. The first bit is presented (rx_valid with rx_bit) 8 ticks after the rising edge is detected, which is 10 ticks after the change.
- R7: After each sample, an edge of the opposite level detected within the next 16 ticks re-centres the receiver. The next bit is presented 8 ticks after that detection, which tolerates bit periods of 14 to 18 ticks.
- R8: If no such edge is detected in the 16 ticks after a sample, the previous value is presented again 16 ticks after that sample. An edge detected on the 16th tick wins over the repeat.
- R9: Setting mode_rx to 1 aborts a symbol in progress: line_oe and line_out are 0 from the next clock. While mode_rx is 1, tx_ready is 0 and tx_valid has no effect on the line.
- R10: With rx_en low, no bit is presented. After a sync timeout, edges on the line produce no bits until rx_en is dropped and raised again.
- R11: rx_valid and sync_fail are each high for a single clock per event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Clock enable, one pulse per line tick |
| mode_rx | input | 1 | 0 selects transmit, 1 selects receive |
| tx_valid | input | 1 | Symbol request |
| tx_sym | input | 1 | 0 = J (line low), 1 = K (line high) |
| tx_ready | output | 1 | Symbol is taken on this edge when tx_valid is high |
| rx_en | input | 1 | Receive enable; its rise starts the sync search |
| rx_bit | output | 1 | Sampled line level |
| rx_valid | output | 1 | One-cycle strobe qualifying rx_bit |
| sync_fail | output | 1 | One-cycle pulse on sync timeout |
| line_in | input | 1 | Line level seen at the pin |
| line_out | output | 1 | Line level to drive |
| line_oe | output | 1 | Output enable; 0 leaves the line to the pull-down |

## Verification
The receiver is driven with a bit stream whose periods are nominal, short by two ticks, long by two ticks, and one tick off. It also contains runs of two, three and six equal bits, plus a gap of exactly 24 ticks that puts an edge on the repeat tick. A reference model derived from the requirements predicts every bit's value and tick. The cases tell re-centring apart from free-running, repeat timing apart from re-centring, and edge-versus-repeat priority. The sync search is tried with no edge, with an edge on the last accepted tick and with one a tick late. This pins the 272-tick window from both sides. On the transmit side, single symbols, back-to-back symbols and a mode switch in mid-bit separate the exact bit length, gapless chaining and abort behaviour.

// File: rtl/lsx_pkg.sv
package lsx_pkg;
  localparam int TICKS_PER_BIT = 16;
  localparam int SYNC_BITS     = 17;
  localparam int SYNC_STAGES   = 2;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_SYNC,
    RX_HALF,
    RX_SRCH,
    RX_HOLD
  } rx_state_e;

  typedef enum logic {
    TX_IDLE,
    TX_BUSY
  } tx_state_e;
endpackage

// File: rtl/lsx_rst_sync.sv
module lsx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/lsx_in_sync.sv
module lsx_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ff_q[g] <= 1'b0;
          else        ff_q[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ff_q[g] <= 1'b0;
          else        ff_q[g] <= ff_q[g-1];
        end
      end
    end
  endgenerate

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/lsx_tx_timer.sv
module lsx_tx_timer
  import lsx_pkg::*;
#(
  parameter int BIT_TICKS = TICKS_PER_BIT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic req_valid,
  input  logic req_sym,
  output logic req_ready,
  output logic line_out,
  output logic line_oe
);
  localparam int CW = (BIT_TICKS > 1) ? $clog2(BIT_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BIT_TICKS - 1);

  tx_state_e       st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            sym_q, sym_d;
  logic            last_tick;

  assign last_tick = (st_q == TX_BUSY) && tick && (cnt_q == LAST);
  assign req_ready = en && ((st_q == TX_IDLE) || last_tick);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    sym_d = sym_q;
    if (!en) begin
      st_d  = TX_IDLE;
      cnt_d = '0;
      sym_d = 1'b0;
    end else if (req_ready && req_valid) begin
      st_d  = TX_BUSY;
      cnt_d = '0;
      sym_d = req_sym;
    end else if (last_tick) begin
      st_d  = TX_IDLE;
      cnt_d = '0;
      sym_d = 1'b0;
    end else if ((st_q == TX_BUSY) && tick) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TX_IDLE;
      cnt_q <= '0;
      sym_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sym_q <= sym_d;
    end
  end

  assign line_oe  = (st_q == TX_BUSY);
  assign line_out = line_oe & sym_q;

  // R2
  tx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> line_oe && (line_out == $past(req_sym)));

  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe && !req_ready && en |=> line_oe && $stable(line_out));

  // R9
  tx_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !line_oe && !line_out);
endmodule

// File: rtl/lsx_rx_engine.sv
module lsx_rx_engine
  import lsx_pkg::*;
#(
  parameter int BIT_TICKS = TICKS_PER_BIT,
  parameter int SYNC_WIN  = SYNC_BITS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic line_s,
  output logic bit_o,
  output logic valid_o,
  output logic fail_o
);
  localparam int HALF_TICKS = BIT_TICKS / 2;
  localparam int SYNC_TICKS = BIT_TICKS * SYNC_WIN;
  localparam int CW         = $clog2(SYNC_TICKS);
  localparam logic [CW-1:0] SYNC_LAST = CW'(SYNC_TICKS - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF_TICKS - 1);
  localparam logic [CW-1:0] BIT_LAST  = CW'(BIT_TICKS - 1);

  rx_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          prev_q;
  logic          last_q, last_d;
  logic          bit_q, bit_d;
  logic          valid_q, valid_d;
  logic          fail_q, fail_d;
  logic          rise, fall, want;

  assign rise = tick &  line_s & ~prev_q;
  assign fall = tick & ~line_s &  prev_q;
  assign want = last_q ? fall : rise;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    last_d  = last_q;
    bit_d   = bit_q;
    valid_d = 1'b0;
    fail_d  = 1'b0;
    if (!en) begin
      st_d  = RX_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        RX_IDLE: begin
          st_d  = RX_SYNC;
          cnt_d = '0;
        end
        RX_SYNC: begin
          if (tick) begin
            if (rise) begin
              st_d  = RX_HALF;
              cnt_d = '0;
            end else if (cnt_q == SYNC_LAST) begin
              st_d   = RX_HOLD;
              cnt_d  = '0;
              fail_d = 1'b1;
            end else begin
              cnt_d = cnt_q + CW'(1);
            end
          end
        end
        RX_HALF: begin
          if (tick) begin
            if (cnt_q == HALF_LAST) begin
              st_d    = RX_SRCH;
              cnt_d   = '0;
              bit_d   = line_s;
              last_d  = line_s;
              valid_d = 1'b1;
            end else begin
              cnt_d = cnt_q + CW'(1);
            end
          end
        end
        RX_SRCH: begin
          if (tick) begin
            if (want) begin
              st_d  = RX_HALF;
              cnt_d = '0;
            end else if (cnt_q == BIT_LAST) begin
              cnt_d   = '0;
              bit_d   = last_q;
              valid_d = 1'b1;
            end else begin
              cnt_d = cnt_q + CW'(1);
            end
          end
        end
        RX_HOLD: begin
          cnt_d = '0;
        end
        default: begin
          st_d  = RX_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      prev_q  <= 1'b0;
      last_q  <= 1'b0;
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      last_q  <= last_d;
      bit_q   <= bit_d;
      valid_q <= valid_d;
      fail_q  <= fail_d;
      if (tick) prev_q <= line_s;
    end
  end

  assign bit_o   = bit_q;
  assign valid_o = valid_q;
  assign fail_o  = fail_q;

  // R11
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R11
  fail_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |=> !fail_q);

  // R10
  rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !valid_q && !fail_q);

  // R5
  sync_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |-> !valid_q);

  // R10
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_HOLD) |=> !valid_q);
endmodule

// File: rtl/lsusb_bit_xcvr.sv
module lsusb_bit_xcvr
  import lsx_pkg::*;
#(
  parameter int BIT_TICKS = TICKS_PER_BIT,
  parameter int SYNC_WIN  = SYNC_BITS,
  parameter int IN_STAGES = SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic mode_rx,
  input  logic tx_valid,
  input  logic tx_sym,
  output logic tx_ready,
  input  logic rx_en,
  output logic rx_bit,
  output logic rx_valid,
  output logic sync_fail,
  input  logic line_in,
  output logic line_out,
  output logic line_oe
);
  logic rst_n_s;
  logic line_s;
  logic tx_en;
  logic rx_on;

  assign tx_en = ~mode_rx;
  assign rx_on = mode_rx & rx_en;

  lsx_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  lsx_in_sync #(.STAGES(IN_STAGES)) u_insync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d     (line_in),
    .q     (line_s)
  );

  lsx_tx_timer #(.BIT_TICKS(BIT_TICKS)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .tick      (tick_en),
    .en        (tx_en),
    .req_valid (tx_valid),
    .req_sym   (tx_sym),
    .req_ready (tx_ready),
    .line_out  (line_out),
    .line_oe   (line_oe)
  );

  lsx_rx_engine #(.BIT_TICKS(BIT_TICKS), .SYNC_WIN(SYNC_WIN)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .tick    (tick_en),
    .en      (rx_on),
    .line_s  (line_s),
    .bit_o   (rx_bit),
    .valid_o (rx_valid),
    .fail_o  (sync_fail)
  );

  // R9
  mode_release_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    mode_rx |=> !line_oe && !tx_ready);
endmodule

// File: tb/tb_lsusb_bit_xcvr.sv
module tb_lsusb_bit_xcvr;
  logic clk, rst_n, tick_en, mode_rx, tx_valid, tx_sym, rx_en, line_in;
  logic tx_ready, rx_bit, rx_valid, sync_fail, line_out, line_oe;

  lsusb_bit_xcvr dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_rx(mode_rx),
    .tx_valid(tx_valid), .tx_sym(tx_sym), .tx_ready(tx_ready),
    .rx_en(rx_en), .rx_bit(rx_bit), .rx_valid(rx_valid),
    .sync_fail(sync_fail), .line_in(line_in), .line_out(line_out),
    .line_oe(line_oe)
  );

  // line segments {level, duration in ticks}
  localparam int NSEG = 13;
  localparam logic [8:0] SEG [NSEG] = '{
    9'h014, 9'h110, 9'h010, 9'h120, 9'h00E, 9'h112, 9'h030,
    9'h118, 9'h011, 9'h10F, 9'h060, 9'h110, 9'h028
  };

  int checks = 0, failures = 0;
  int tcnt = 0;
  logic last_was_tick = 1'b0;
  int nv = 0, nf = 0, dbl = 0, fail_t = 0;
  int got_t [128];
  logic got_v [128];
  logic valid_prev = 1'b0;
  int exp_t [64];
  logic exp_v [64];
  int ne = 0;
  int ch [NSEG];

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial tick_en = 1'b0;
  always @(posedge clk) begin
    last_was_tick <= tick_en;
    if (tick_en) tcnt <= tcnt + 1;
    tick_en <= ~tick_en;
  end

  always @(negedge clk) begin
    if (rx_valid) begin
      if (nv < 128) begin
        got_t[nv] = tcnt;
        got_v[nv] = rx_bit;
      end
      nv++;
      if (valid_prev) dbl++;
    end
    valid_prev = rx_valid;
    if (sync_fail) begin
      fail_t = tcnt;
      nf++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic next_tick();
    do @(negedge clk); while (!last_was_tick);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) next_tick();
  endtask

  task automatic send_sym(input logic s, output int t);
    tx_valid = 1'b1;
    tx_sym   = s;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    t = tcnt;
  endtask

  task automatic push(input logic v, input int t);
    if (ne < 64) begin
      exp_t[ne] = t;
      exp_v[ne] = v;
    end
    ne++;
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int c0, t1, t2, d_end, s_t, det_n, vb, fb;
    rst_n = 1'b0; mode_rx = 1'b0; tx_valid = 1'b0; tx_sym = 1'b0;
    rx_en = 1'b0; line_in = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 line_oe in reset", int'(line_oe), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 line_oe", int'(line_oe), 0);
    chk("R1 line_out", int'(line_out), 0);
    chk("R1 rx_valid", int'(rx_valid), 0);
    chk("R1 sync_fail", int'(sync_fail), 0);
    chk("R1 tx_ready", int'(tx_ready), 1);

    // single J symbol
    next_tick();
    send_sym(1'b0, t1);
    tx_valid = 1'b0;
    chk("R2 J oe", int'(line_oe), 1);
    chk("R2 J level", int'(line_out), 0);
    ticks(5);
    chk("R3 ready low while busy", int'(tx_ready), 0);
    ticks(10);
    chk("R3 still driven at tick 15", int'(line_oe), 1);
    next_tick();
    chk("R3 released after 16 ticks", int'(line_oe), 0);
    chk("R4 released level", int'(line_out), 0);

    // K then J back to back
    next_tick();
    send_sym(1'b1, t1);
    chk("R2 K level", int'(line_out), 1);
    chk("R2 K oe", int'(line_oe), 1);
    send_sym(1'b0, t2);
    tx_valid = 1'b0;
    chk("R4 chained start spacing", t2 - t1, 16);
    chk("R4 no gap oe", int'(line_oe), 1);
    chk("R4 second level J", int'(line_out), 0);
    ticks(15);
    chk("R3 second held", int'(line_oe), 1);
    next_tick();
    chk("R4 release after chain", int'(line_oe), 0);

    // mode switch aborts a K symbol
    next_tick();
    send_sym(1'b1, t1);
    tx_valid = 1'b0;
    ticks(5);
    mode_rx = 1'b1;
    @(negedge clk);
    chk("R9 abort oe", int'(line_oe), 0);
    chk("R9 abort level", int'(line_out), 0);
    tx_valid = 1'b1; tx_sym = 1'b1;
    ticks(20);
    chk("R9 tx ignored oe", int'(line_oe), 0);
    chk("R9 tx_ready in rx mode", int'(tx_ready), 0);
    tx_valid = 1'b0;

    // receive stream walk
    fb = nf;
    next_tick();
    rx_en = 1'b1;
    vb = nv;
    for (int k = 0; k < NSEG; k++) begin
      line_in = SEG[k][8];
      ch[k] = tcnt;
      ticks(int'(SEG[k][7:0]));
    end
    d_end = tcnt;
    rx_en = 1'b0;
    ticks(4);
    // reference: R6 first sample, R7 re-centre, R8 repeat and tie
    ne = 0;
    s_t = ch[1] + 10;
    push(SEG[1][8], s_t);
    for (int k = 1; k < NSEG; k++) begin
      det_n = (k + 1 < NSEG) ? ch[k+1] + 2 : 32'h3fff_ffff;
      while ((s_t + 16 < det_n) && (s_t + 16 <= d_end)) begin
        s_t += 16;
        push(SEG[k][8], s_t);
      end
      if ((k + 1 < NSEG) && (det_n <= s_t + 16)) begin
        s_t = det_n + 8;
        if (s_t <= d_end) push(SEG[k+1][8], s_t);
      end
    end
    chk("R7 R8 number of bits", nv - vb, ne);
    for (int i = 0; i < ne && i < 64; i++) begin
      chk((i == 0) ? "R6 first bit tick" : "R7 R8 bit tick",
          got_t[vb+i], exp_t[i]);
      chk((i == 0) ? "R6 first bit value" : "R7 R8 bit value",
          int'(got_v[vb+i]), int'(exp_v[i]));
    end
    chk("R5 no timeout during stream", nf - fb, 0);
    vb = nv;
    line_in = 1'b1; ticks(20); line_in = 1'b0; ticks(80);
    chk("R10 no bits with rx_en low", nv - vb, 0);

    // sync timeout
    next_tick();
    rx_en = 1'b1; c0 = tcnt; vb = nv; fb = nf;
    ticks(300);
    chk("R5 one timeout", nf - fb, 1);
    chk("R5 timeout tick", fail_t - c0, 272);
    chk("R10 no bits on timeout", nv - vb, 0);
    line_in = 1'b1; ticks(20); line_in = 1'b0; ticks(40);
    chk("R10 quiet after timeout", nv - vb, 0);
    chk("R11 single timeout pulse", nf - fb, 1);
    rx_en = 1'b0;
    ticks(4);

    // edge detected on the last window tick
    next_tick();
    rx_en = 1'b1; c0 = tcnt; vb = nv; fb = nf;
    ticks(270);
    line_in = 1'b1;
    ticks(20);
    chk("R5 late edge accepted", nf - fb, 0);
    chk("R5 one bit after late edge", nv - vb, 1);
    chk("R6 bit tick after late edge", got_t[vb] - c0, 280);
    chk("R6 bit value after late edge", int'(got_v[vb]), 1);
    rx_en = 1'b0; line_in = 1'b0;
    ticks(6);

    // edge one tick too late
    next_tick();
    rx_en = 1'b1; c0 = tcnt; vb = nv; fb = nf;
    ticks(271);
    line_in = 1'b1;
    ticks(20);
    chk("R5 too late edge times out", nf - fb, 1);
    chk("R5 too late timeout tick", fail_t - c0, 272);
    chk("R10 no bit after too late edge", nv - vb, 0);
    rx_en = 1'b0; line_in = 1'b0;
    ticks(4);

    chk("R11 rx_valid single cycle", dbl, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule